// File: doc/BRIEF.md
# Serial ADC Power-Mode Host Controller

This block is the host end of a three-wire link to a sampling converter that delivers one result per 16-clock serial frame. It drives chip-select and the serial clock, and it samples the converter's data line. A single command input asks for a conversion, for partial power-down, for full power-down or for a wake-up. The controller keeps its own record of the converter's power mode and turns each command into the short series of frames that the converter needs. A frame is either a full 16-clock frame, or a frame cut short by raising chip-select after the 4th falling clock edge.

Two waits are enforced. A quiet gap follows every frame. A wake-up wait, counted from chip-select falling, follows any full frame sent while the converter may be fully powered down. After power is applied the mode is unknown, so the first command always begins with a dummy full frame. When the last frame of a command ends, a one-cycle done pulse reports the mode that results. A conversion also returns the 12 data bits.

Top module: `adc_pwr_host`

## Requirements
- R1: After a synchronous reset, cs_n is 1, sclk is 1, busy is 0, done and result_valid are 0, and done_status holds 3 (mode unknown).
- R2: A frame starts with cs_n falling while sclk is high. sclk then toggles every sclk_half system clocks, where a value of 0 acts as 1. sclk is high whenever cs_n is high.
- R3: A full frame (dummy or conversion) keeps cs_n low for 16 falling sclk edges. cs_n rises in the same cycle that sclk returns high after the 16th fall.
- R4: A cut-short frame raises cs_n in the same cycle that sclk returns high after its 4th falling edge.
- R5: cmd_op encoding is 0 convert, 1 partial, 2 full, 3 wake. From a powered-down or unknown mode, convert, wake and partial start with one dummy full frame. Convert then sends one conversion frame, and partial then sends one cut frame. Full sends two cut frames from normal, one from partial, none from full, and a dummy plus two cuts from unknown. A command that asks for the current mode sends no frame.
- R6: A full frame started while the mode is full or unknown arms a wake wait of wake_cycles, counted from the chip-select fall. No further frame starts until that wait has run out.
- R7: After a frame ends, the next chip-select fall comes no earlier than quiet_cycles+1 cycles later.
- R8: busy is high from the cycle after a command is accepted until all frames are done and both waits have run out. A command presented while busy is ignored.
- R9: done is a one-cycle pulse issued one cycle after the last frame ends, or one cycle after acceptance when no frame is needed. done_status then gives the mode: 0 normal, 1 partial, 2 full.
- R10: sdata is sampled as sclk falls, MSB first. The result is the last 12 of the 16 bits sampled in the conversion frame, and the first 4 are dropped. result_valid pulses with done only for the convert command.
- R11: A full frame leaves the mode normal. A cut frame moves normal to partial and partial to full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | Command code |
| sclk_half | input | 8 | sclk half-period in system clocks |
| wake_cycles | input | 16 | Wake-up wait length |
| quiet_cycles | input | 16 | Quiet gap length after each frame |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock |
| busy | output | 1 | Command in progress or wait running |
| done | output | 1 | Command finished pulse |
| done_status | output | 2 | Resulting power mode |
| result_valid | output | 1 | Result valid pulse |
| result | output | 12 | Conversion result |

## Verification
Each command is issued from each power mode: unknown, normal, partial and full. These cases separate a dummy frame from a conversion frame, one cut frame from two, and a command that needs no frame at all. Wake-up waits longer than a frame show that the wake timer, and not the quiet timer, holds the next frame back. Pairs of cut frames show the quiet gap on its own. Half-periods of 0, 1 and 2 and a quiet time of zero test the edge counting. Data words whose leading bits are nonzero show that only the last 12 sampled bits reach the result. A command sent in the middle of a frame shows that requests are ignored while busy.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        OP_CONVERT = 2'd0,
        OP_PARTIAL = 2'd1,
        OP_FULL    = 2'd2,
        OP_WAKE    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        MD_NORMAL  = 2'd0,
        MD_PARTIAL = 2'd1,
        MD_FULL    = 2'd2,
        MD_UNKNOWN = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        FK_DUMMY = 2'd0,
        FK_CUT   = 2'd1,
        FK_CONV  = 2'd2
    } frame_e;

    typedef struct packed {
        logic       dummy;
        logic [1:0] cuts;
        logic       conv;
    } plan_t;

    function automatic plan_t make_plan(op_e op, mode_e md);
        plan_t p;
        logic  awake;
        p     = '0;
        awake = (md == MD_NORMAL);
        case (op)
            OP_CONVERT: begin
                p.dummy = !awake;
                p.conv  = 1'b1;
            end
            OP_PARTIAL: begin
                if (md != MD_PARTIAL) begin
                    p.dummy = !awake;
                    p.cuts  = 2'd1;
                end
            end
            OP_FULL: begin
                case (md)
                    MD_NORMAL:  p.cuts = 2'd2;
                    MD_PARTIAL: p.cuts = 2'd1;
                    MD_UNKNOWN: begin
                        p.dummy = 1'b1;
                        p.cuts  = 2'd2;
                    end
                    default:    p.cuts = 2'd0;
                endcase
            end
            default: p.dummy = !awake;
        endcase
        return p;
    endfunction

    function automatic mode_e next_mode(frame_e kind, mode_e md);
        if (kind != FK_CUT) return MD_NORMAL;
        if (md == MD_NORMAL) return MD_PARTIAL;
        return MD_FULL;
    endfunction

endpackage

// File: rtl/adc_frame_engine.sv
module adc_frame_engine #(
    parameter int DIVW     = 8,
    parameter int FALLW    = 5,
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [FALLW-1:0]    target,
    input  logic [DIVW-1:0]     half,
    input  logic                sdata,
    output logic                cs_n,
    output logic                sclk,
    output logic                last_edge,
    output logic [RES_BITS-1:0] shreg
);
    logic [DIVW-1:0]  cnt;
    logic [DIVW-1:0]  half_m1;
    logic [FALLW-1:0] falls;
    logic [FALLW-1:0] target_q;
    logic             tick;

    always_comb begin
        half_m1   = (half == '0) ? '0 : half - 1'b1;
        tick      = !cs_n && (cnt == half_m1);
        last_edge = tick && !sclk && (falls == target_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n     <= 1'b1;
            sclk     <= 1'b1;
            cnt      <= '0;
            falls    <= '0;
            target_q <= '0;
            shreg    <= '0;
        end else if (start) begin
            cs_n     <= 1'b0;
            sclk     <= 1'b1;
            cnt      <= '0;
            falls    <= '0;
            target_q <= target;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= !sclk;
            if (sclk) begin
                falls <= falls + 1'b1;
                shreg <= {shreg[RES_BITS-2:0], sdata};
            end else if (falls == target_q) begin
                cs_n <= 1'b1;
            end
        end else if (!cs_n) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the serial clock rests high outside a frame
    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R3: never more falling edges than the frame calls for
    p_falls_bound_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (falls <= target_q));

endmodule

// File: rtl/adc_wait_timers.sv
module adc_wait_timers #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wake_load,
    input  logic [CNTW-1:0] wake_val,
    input  logic            quiet_load,
    input  logic [CNTW-1:0] quiet_val,
    output logic            clear
);
    logic [CNTW-1:0] wake_q;
    logic [CNTW-1:0] quiet_q;

    assign clear = (wake_q == '0) && (quiet_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q  <= '0;
            quiet_q <= '0;
        end else begin
            if (wake_load)          wake_q <= wake_val;
            else if (wake_q != '0)  wake_q <= wake_q - 1'b1;
            if (quiet_load)         quiet_q <= quiet_val;
            else if (quiet_q != '0) quiet_q <= quiet_q - 1'b1;
        end
    end

    // R7: the quiet gap counts down one per cycle once loaded
    p_quiet_down_r7: assert property (@(posedge clk) disable iff (rst)
        (quiet_q != '0 && !quiet_load) |=> (quiet_q == $past(quiet_q) - 1'b1));

    // R6: the wake wait counts down one per cycle once loaded
    p_wake_down_r6: assert property (@(posedge clk) disable iff (rst)
        (wake_q != '0 && !wake_load) |=> (wake_q == $past(wake_q) - 1'b1));

endmodule

// File: rtl/adc_power_seq.sv
module adc_power_seq
    import adc_pwr_pkg::*;
#(
    parameter int FALLW       = 5,
    parameter int FRAME_FALLS = 16,
    parameter int CUT_FALLS   = 4,
    parameter int RES_BITS    = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic                timers_clear,
    input  logic                last_edge,
    input  logic [RES_BITS-1:0] shreg,
    output logic                start,
    output logic [FALLW-1:0]    target,
    output logic                wake_arm,
    output logic                idle,
    output logic                done,
    output mode_e               status,
    output logic                result_valid,
    output logic [RES_BITS-1:0] result
);
    typedef enum logic [1:0] {S_IDLE, S_GAP, S_FRAME} st_e;

    st_e    st;
    plan_t  plan;
    frame_e kind;
    frame_e pick;
    mode_e  mode;
    logic   conv_cmd;
    logic   plan_empty;

    always_comb begin
        plan_empty = !plan.dummy && (plan.cuts == 2'd0) && !plan.conv;
        if (plan.dummy)             pick = FK_DUMMY;
        else if (plan.cuts != 2'd0) pick = FK_CUT;
        else                        pick = FK_CONV;
        start    = (st == S_GAP) && !plan_empty && timers_clear;
        target   = (pick == FK_CUT) ? FALLW'(CUT_FALLS) : FALLW'(FRAME_FALLS);
        wake_arm = start && (pick != FK_CUT) &&
                   ((mode == MD_FULL) || (mode == MD_UNKNOWN));
        idle     = (st == S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            plan         <= '0;
            kind         <= FK_DUMMY;
            mode         <= MD_UNKNOWN;
            conv_cmd     <= 1'b0;
            done         <= 1'b0;
            status       <= MD_UNKNOWN;
            result_valid <= 1'b0;
            result       <= '0;
        end else begin
            done         <= 1'b0;
            result_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (cmd_valid && timers_clear) begin
                        plan     <= make_plan(op_e'(cmd_op), mode);
                        conv_cmd <= (op_e'(cmd_op) == OP_CONVERT);
                        st       <= S_GAP;
                    end
                end
                S_GAP: begin
                    if (plan_empty) begin
                        done         <= 1'b1;
                        status       <= mode;
                        result_valid <= conv_cmd;
                        st           <= S_IDLE;
                    end else if (timers_clear) begin
                        kind <= pick;
                        if (plan.dummy)             plan.dummy <= 1'b0;
                        else if (plan.cuts != 2'd0) plan.cuts  <= plan.cuts - 2'd1;
                        else                        plan.conv  <= 1'b0;
                        st <= S_FRAME;
                    end
                end
                default: begin
                    if (last_edge) begin
                        mode <= next_mode(kind, mode);
                        if (kind == FK_CONV) result <= shreg;
                        st <= S_GAP;
                    end
                end
            endcase
        end
    end

    // R9: done lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: a result is only flagged together with done
    p_result_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> done);

endmodule

// File: rtl/adc_pwr_host.sv
module adc_pwr_host
    import adc_pwr_pkg::*;
#(
    parameter int DIVW        = 8,
    parameter int CNTW        = 16,
    parameter int FRAME_FALLS = 16,
    parameter int CUT_FALLS   = 4,
    parameter int RES_BITS    = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [DIVW-1:0]     sclk_half,
    input  logic [CNTW-1:0]     wake_cycles,
    input  logic [CNTW-1:0]     quiet_cycles,
    input  logic                sdata,
    output logic                cs_n,
    output logic                sclk,
    output logic                busy,
    output logic                done,
    output logic [1:0]          done_status,
    output logic                result_valid,
    output logic [RES_BITS-1:0] result
);
    localparam int FALLW = $clog2(FRAME_FALLS + 1);

    logic                start;
    logic [FALLW-1:0]    target;
    logic                wake_arm;
    logic                last_edge;
    logic                tim_clear;
    logic                seq_idle;
    logic [RES_BITS-1:0] shreg;
    mode_e               status;

    adc_frame_engine #(
        .DIVW(DIVW), .FALLW(FALLW), .RES_BITS(RES_BITS)
    ) u_engine (
        .clk(clk), .rst(rst), .start(start), .target(target),
        .half(sclk_half), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
        .last_edge(last_edge), .shreg(shreg)
    );

    adc_wait_timers #(.CNTW(CNTW)) u_timers (
        .clk(clk), .rst(rst),
        .wake_load(wake_arm), .wake_val(wake_cycles),
        .quiet_load(last_edge), .quiet_val(quiet_cycles),
        .clear(tim_clear)
    );

    adc_power_seq #(
        .FALLW(FALLW), .FRAME_FALLS(FRAME_FALLS),
        .CUT_FALLS(CUT_FALLS), .RES_BITS(RES_BITS)
    ) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .timers_clear(tim_clear), .last_edge(last_edge), .shreg(shreg),
        .start(start), .target(target), .wake_arm(wake_arm),
        .idle(seq_idle), .done(done), .status(status),
        .result_valid(result_valid), .result(result)
    );

    assign busy        = !seq_idle || !tim_clear;
    assign done_status = status;

    // R6: a frame only opens once both waits have expired
    p_start_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(tim_clear));

    // R8: the block reports busy during every frame
    p_busy_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

endmodule

// File: tb/adc_pwr_host_bench.sv
`timescale 1ns/1ps
module adc_pwr_host_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  sclk_half = 8'd2;
    logic [15:0] wake_cycles = 16'd100;
    logic [15:0] quiet_cycles = 16'd5;
    logic        sdata = 1'b0;
    logic        cs_n, sclk, busy, done, result_valid;
    logic [1:0]  done_status;
    logic [11:0] result;

    int tests = 0;
    int fails = 0;

    always #4 clk = !clk;

    adc_pwr_host u_adc_pwr_host (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .sclk_half(sclk_half), .wake_cycles(wake_cycles),
        .quiet_cycles(quiet_cycles), .sdata(sdata), .cs_n(cs_n),
        .sclk(sclk), .busy(busy), .done(done), .done_status(done_status),
        .result_valid(result_valid), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // converter model: shifts one bit out per falling sclk edge
    logic [15:0] adc_word = 16'h0000;
    int adc_j = 0;
    logic adc_prev_sclk = 1'b1;
    always @(negedge clk) begin
        if (cs_n === 1'b1) adc_j = 0;
        else if (adc_prev_sclk && !sclk) adc_j++;
        adc_prev_sclk = sclk;
        sdata = (adc_j < 16) ? adc_word[15 - adc_j] : 1'b0;
    end

    // frame monitor
    int cyc = 0;
    int n_frames = 0;
    int fall_t[0:7];
    logic mon_prev_cs = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (mon_prev_cs && !cs_n) begin
            if (n_frames < 8) fall_t[n_frames] = cyc;
            n_frames++;
        end
        mon_prev_cs = cs_n;
    end

    // behavioural reference model, advanced at every rising edge
    int m_phase = 0, m_e = 0, m_nf = 0, m_kind = 0, m_qc = 0, m_wk = 0;
    int m_mode = 3, m_conv = 0;
    int fq[$];
    logic e_cs = 1'b1, e_sclk = 1'b1, e_busy = 1'b0, e_done = 1'b0, e_rv = 1'b0;
    logic [1:0]  e_st = 2'd3;
    logic [11:0] e_res = 12'd0;
    bit started = 1'b0;

    always @(posedge clk) begin
        int hh, pq, pw;
        bit busy_now;
        hh = (sclk_half == 0) ? 1 : int'(sclk_half);
        started = 1'b1;
        if (rst) begin
            m_phase = 0; m_e = 0; m_qc = 0; m_wk = 0; m_mode = 3; m_conv = 0;
            fq.delete();
            e_done = 1'b0; e_rv = 1'b0; e_st = 2'd3; e_res = 12'd0;
        end else begin
            busy_now = (m_phase != 0) || (m_qc > 0) || (m_wk > 0);
            pq = m_qc; pw = m_wk;
            if (m_qc > 0) m_qc--;
            if (m_wk > 0) m_wk--;
            e_done = 1'b0; e_rv = 1'b0;
            case (m_phase)
                0: if (cmd_valid && !busy_now) begin
                    m_conv = (cmd_op == 2'd0);
                    case (cmd_op)
                        2'd0: begin
                            if (m_mode != 0) fq.push_back(0);
                            fq.push_back(2);
                        end
                        2'd1: if (m_mode != 1) begin
                            if (m_mode != 0) fq.push_back(0);
                            fq.push_back(1);
                        end
                        2'd2: begin
                            if (m_mode == 3) fq.push_back(0);
                            if (m_mode == 0 || m_mode == 3) fq.push_back(1);
                            if (m_mode != 2) fq.push_back(1);
                        end
                        default: if (m_mode != 0) fq.push_back(0);
                    endcase
                    m_phase = 1;
                end
                1: if (fq.size() == 0) begin
                    e_done = 1'b1; e_st = 2'(m_mode); e_rv = (m_conv != 0);
                    m_phase = 0;
                end else if (pq == 0 && pw == 0) begin
                    m_kind = fq.pop_front();
                    m_nf = (m_kind == 1) ? 4 : 16;
                    m_e = 0;
                    if (m_kind != 1 && (m_mode == 2 || m_mode == 3)) m_wk = int'(wake_cycles);
                    m_phase = 2;
                end
                default: begin
                    m_e++;
                    if (m_e == 2 * m_nf * hh) begin
                        m_phase = 1;
                        m_qc = int'(quiet_cycles);
                        if (m_kind == 1) m_mode = (m_mode == 0) ? 1 : 2;
                        else m_mode = 0;
                        if (m_kind == 2) e_res = adc_word[11:0];
                    end
                end
            endcase
        end
        e_cs   = (m_phase != 2);
        e_sclk = (m_phase == 2) ? (((m_e / hh) % 2) == 0) : 1'b1;
        e_busy = (m_phase != 0) || (m_qc > 0) || (m_wk > 0);
    end

    always @(negedge clk) begin
        if (started) begin
            tests++;
            if (cs_n !== e_cs) begin
                fails++; $display("[TB] FAIL R3 R4 R6 R7 cs_n act=%0d exp=%0d", cs_n, e_cs);
            end
            if (sclk !== e_sclk) begin
                fails++; $display("[TB] FAIL R2 sclk act=%0d exp=%0d", sclk, e_sclk);
            end
            if (busy !== e_busy) begin
                fails++; $display("[TB] FAIL R8 busy act=%0d exp=%0d", busy, e_busy);
            end
            if (done !== e_done || done_status !== e_st) begin
                fails++; $display("[TB] FAIL R9 done/status act=%0d/%0d exp=%0d/%0d",
                                  done, done_status, e_done, e_st);
            end
            if (result_valid !== e_rv || result !== e_res) begin
                fails++; $display("[TB] FAIL R10 result act=%0d/%0h exp=%0d/%0h",
                                  result_valid, result, e_rv, e_res);
            end
        end
    end

    task automatic run_cmd(input int op, input int exp_st, input int exp_frames,
                           input logic [15:0] word, input string tag);
        while (busy) @(negedge clk);
        adc_word = word;
        n_frames = 0;
        cmd_op = 2'(op);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(done_status == 2'(exp_st), {tag, " R9 R11 status"}, done_status, exp_st);
        chk(n_frames == exp_frames, {tag, " R5 frames"}, n_frames, exp_frames);
        if (op == 0) begin
            chk(result_valid == 1'b1, {tag, " R10 valid"}, result_valid, 1);
            chk(result == word[11:0], {tag, " R10 value"}, result, word[11:0]);
        end else begin
            chk(result_valid == 1'b0, {tag, " R10 no valid"}, result_valid, 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        fails++;
        $display("[TB] FAIL R8 watchdog expired act=busy exp=idle");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 lines idle", {cs_n, sclk}, 3);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(done_status == 2'd3, "R1 status unknown", done_status, 3);

        // unknown -> convert: dummy then conversion, wake wait gates (R6)
        run_cmd(0, 0, 2, 16'hF5A3, "unknown convert");
        chk(fall_t[1] - fall_t[0] == 101, "R6 wake gap", fall_t[1] - fall_t[0], 101);

        sclk_half = 8'd1;
        run_cmd(0, 0, 1, 16'h0C3E, "normal convert");
        run_cmd(1, 1, 1, 16'h0000, "normal partial");
        run_cmd(1, 1, 0, 16'h0000, "partial partial");
        run_cmd(2, 2, 1, 16'h0000, "partial full");
        run_cmd(2, 2, 0, 16'h0000, "full full");
        run_cmd(0, 0, 2, 16'h0ABC, "full convert");
        sclk_half = 8'd2;
        run_cmd(2, 2, 2, 16'h0000, "normal full");
        chk(fall_t[1] - fall_t[0] == 22, "R7 quiet gap", fall_t[1] - fall_t[0], 22);
        run_cmd(3, 0, 1, 16'h0000, "full wake");
        run_cmd(3, 0, 0, 16'h0000, "normal wake");
        run_cmd(2, 2, 2, 16'h0000, "to full again");
        run_cmd(1, 1, 2, 16'h0000, "full partial");
        run_cmd(3, 0, 1, 16'h0000, "partial wake");

        // R8: a command during a frame is ignored
        while (busy) @(negedge clk);
        adc_word = 16'h3123; n_frames = 0;
        cmd_op = 2'd0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'd2;
        repeat (10) @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(done_status == 2'd0, "R8 ignored cmd status", done_status, 0);
        chk(n_frames == 1, "R8 ignored cmd frames", n_frames, 1);
        chk(result == 12'h123, "R10 ignored cmd result", result, 12'h123);
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b1, "R8 still in quiet", {done, busy}, 1);

        // R2: half-period 0 acts as 1, zero quiet time
        sclk_half = 8'd0; quiet_cycles = 16'd0;
        run_cmd(0, 0, 1, 16'h0FFF, "half zero convert");
        run_cmd(2, 2, 2, 16'h0000, "half zero full");
        chk(fall_t[1] - fall_t[0] == 9, "R7 zero quiet gap", fall_t[1] - fall_t[0], 9);
        run_cmd(0, 0, 2, 16'h8001, "half zero wake convert");

        repeat (150) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule